// File: doc/BRIEF.md
# Write Data Latency Aligner

This block sits on the controller side of a DDR PHY interface. Every cycle it can take one write word from an upstream queue: a command strobe, one interface-width data word and its byte mask. A run of contiguous strobes is one write burst. The block sends out the command and an undelayed per-lane write enable in the same registered cycle. It holds the data and mask back until the cycle in which the PHY expects them. A second per-lane enable, the shifted one, leads the data by exactly one cycle.

The data offset after the command depends on the DRAM generation. With DDR1 timing, data follows the command on the next clock. With DDR2 timing, the write CAS latency and the PHY write-latency value are added to that one clock. The PHY write-latency value is the number of register stages by which the PHY's data path is longer than its command path. These settings are captured only while the PHY reports that it is not yet initialized. A write offered before initialization completes is dropped, and it sets a sticky error flag.

Top module: `wr_data_aligner`

## Requirements
- R1: The output command strobe and every bit of the undelayed enable are high in the cycle that follows the acceptance of a write word, and low otherwise.
- R2: The shifted enable is high in a cycle exactly when the next cycle carries an accepted data word on the data outputs.
- R3: With `cfg_ddr2` = 0 (DDR1), a word's data and mask appear one cycle after its output command.
- R4: With `cfg_ddr2` = 1 (DDR2), a word's data and mask appear 1 + `cfg_cwl` + `cfg_phy_wlat` cycles after its output command. The maximum settings give 15 cycles.
- R5: In DDR2 mode, a PHY write-latency value of 1 places the data one cycle later than a value of 0 with the same CAS latency.
- R6: Write bursts that abut on input produce one continuous shifted enable, with no low cycle between them.
- R7: All lanes of each enable carry identical values in every cycle.
- R8: `cfg_ddr2`, `cfg_cwl` and `cfg_phy_wlat` are sampled only on clock edges where `phy_init_done` is 0. Changes made while it is 1 have no effect on the data delay.
- R9: A write strobe seen while `phy_init_done` is 0 is not forwarded, and it sets `wr_err_o`. The flag stays high until reset.
- R10: After a synchronous reset, all outputs are 0 and the delay is the DDR1 value.
- R11: Data and mask outputs are all zero in any cycle that carries no accepted data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_init_done | input | 1 | PHY initialized; configuration is captured while low |
| cfg_ddr2 | input | 1 | 0 = DDR1 timing, 1 = DDR2 timing |
| cfg_cwl | input | CWL_W (3) | Write CAS latency in cycles (DDR2 only) |
| cfg_phy_wlat | input | WLAT_W (3) | PHY data-minus-command register stages (DDR2 only) |
| in_wr | input | 1 | Write word present this cycle |
| in_data | input | DFI_DW (64) | Write data word |
| in_mask | input | DFI_MW (8) | Byte mask for the word |
| wr_cmd_o | output | 1 | Registered write command strobe |
| wr_en_unshifted_o | output | NLANE (4) | Per-lane enable aligned to the command |
| wr_en_o | output | NLANE (4) | Per-lane enable one cycle ahead of the data |
| wr_data_o | output | DFI_DW (64) | Delayed write data |
| wr_mask_o | output | DFI_MW (8) | Delayed write mask |
| wr_err_o | output | 1 | Sticky flag for a write offered before initialization |

## Verification
A word that is sampled at edge n shows up on the command strobe and the undelayed enable right after edge n. Its shifted enable follows after edge n+D-1, and its data and mask after edge n+D, where D is 1 in DDR1 mode and 1+CWL+WLAT in DDR2 mode. The error flag rises right after the edge at which the early strobe is sampled. The bench keeps a history of accepted words indexed by edge count and samples every output at the falling edge after each rising edge. From that history it derives the value that each output must have at that edge. Before the bench changes the configuration, it drains the pipeline, so that every word in flight was launched under the delay the bench expects.

// File: rtl/wda_pkg.sv
`timescale 1ns/1ps
package wda_pkg;

  typedef enum logic {
    DRAM_DDR1 = 1'b0,
    DRAM_DDR2 = 1'b1
  } dram_mode_e;

  // Cycles from the output command to the output data word.
  function automatic int unsigned data_delay(dram_mode_e mode, int unsigned cwl,
                                             int unsigned wlat);
    if (mode == DRAM_DDR2) return 1 + cwl + wlat;
    return 1;
  endfunction

endpackage

// File: rtl/wda_cfg.sv
`timescale 1ns/1ps
module wda_cfg #(
  parameter int CWL_W  = 3,
  parameter int WLAT_W = 3,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phy_init_done,
  input  logic              cfg_ddr2,
  input  logic [CWL_W-1:0]  cfg_cwl,
  input  logic [WLAT_W-1:0] cfg_phy_wlat,
  input  logic              in_wr,
  output logic              accept,
  output logic [DLY_W-1:0]  dly,
  output logic              err
);
  import wda_pkg::*;

  dram_mode_e mode;
  assign mode   = dram_mode_e'(cfg_ddr2);
  assign accept = in_wr & phy_init_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly <= DLY_W'(1);
      err <= 1'b0;
    end else begin
      if (!phy_init_done)
        dly <= DLY_W'(data_delay(mode, int'(cfg_cwl), int'(cfg_phy_wlat)));
      if (in_wr && !phy_init_done)
        err <= 1'b1;
    end
  end
endmodule

// File: rtl/wda_delay_line.sv
`timescale 1ns/1ps
module wda_delay_line #(
  parameter int W     = 72,
  parameter int DEPTH = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_v,
  input  logic [W-1:0]              in_d,
  output logic [DEPTH-1:0]          stage_v,
  output logic [DEPTH-1:0][W-1:0]   stage_d
);
  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stage_v[0] <= 1'b0;
          else     stage_v[0] <= in_v;
          stage_d[0] <= in_d;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) stage_v[k] <= 1'b0;
          else     stage_v[k] <= stage_v[k-1];
          stage_d[k] <= stage_d[k-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wda_lane_regs.sv
`timescale 1ns/1ps
module wda_lane_regs #(
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d,
  output logic [NLANE-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < NLANE; i++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/wr_data_aligner.sv
`timescale 1ns/1ps
module wr_data_aligner #(
  parameter int DRAM_DW = 32,
  parameter int RATIO   = 2,
  parameter int CWL_W   = 3,
  parameter int WLAT_W  = 3,
  localparam int DFI_DW = DRAM_DW * RATIO,
  localparam int DFI_MW = DFI_DW / 8,
  localparam int NLANE  = DRAM_DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phy_init_done,
  input  logic              cfg_ddr2,
  input  logic [CWL_W-1:0]  cfg_cwl,
  input  logic [WLAT_W-1:0] cfg_phy_wlat,
  input  logic              in_wr,
  input  logic [DFI_DW-1:0] in_data,
  input  logic [DFI_MW-1:0] in_mask,
  output logic              wr_cmd_o,
  output logic [NLANE-1:0]  wr_en_unshifted_o,
  output logic [NLANE-1:0]  wr_en_o,
  output logic [DFI_DW-1:0] wr_data_o,
  output logic [DFI_MW-1:0] wr_mask_o,
  output logic              wr_err_o
);
  localparam int MAXD  = 1 + (2**CWL_W - 1) + (2**WLAT_W - 1);
  localparam int DEPTH = MAXD;
  localparam int DLY_W = $clog2(MAXD + 1);
  localparam int PW    = DFI_DW + DFI_MW;

  logic                    accept;
  logic [DLY_W-1:0]        dly;
  logic [DEPTH-1:0]        stage_v;
  logic [DEPTH-1:0][PW-1:0] stage_d;
  logic                    en_src;
  logic                    dsrc_v;
  logic [PW-1:0]           dsrc_d;

  wda_cfg #(.CWL_W(CWL_W), .WLAT_W(WLAT_W), .DLY_W(DLY_W)) cfg_i (
    .clk(clk), .rst(rst), .phy_init_done(phy_init_done),
    .cfg_ddr2(cfg_ddr2), .cfg_cwl(cfg_cwl), .cfg_phy_wlat(cfg_phy_wlat),
    .in_wr(in_wr), .accept(accept), .dly(dly), .err(wr_err_o)
  );

  wda_delay_line #(.W(PW), .DEPTH(DEPTH)) line_i (
    .clk(clk), .rst(rst), .in_v(accept), .in_d({in_mask, in_data}),
    .stage_v(stage_v), .stage_d(stage_d)
  );

  // Tap selection: the enable leads the data tap by one stage.
  always_comb begin
    en_src = accept;
    dsrc_v = 1'b0;
    dsrc_d = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(dly) == k + 2) en_src = stage_v[k];
      if (int'(dly) == k + 1) begin
        dsrc_v = stage_v[k];
        dsrc_d = stage_d[k];
      end
    end
  end

  wda_lane_regs #(.NLANE(NLANE)) unsh_i (
    .clk(clk), .rst(rst), .d(accept), .q(wr_en_unshifted_o)
  );

  wda_lane_regs #(.NLANE(NLANE)) shft_i (
    .clk(clk), .rst(rst), .d(en_src), .q(wr_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cmd_o  <= 1'b0;
      wr_data_o <= '0;
      wr_mask_o <= '0;
    end else begin
      wr_cmd_o <= accept;
      if (dsrc_v) begin
        wr_data_o <= dsrc_d[DFI_DW-1:0];
        wr_mask_o <= dsrc_d[PW-1:DFI_DW];
      end else begin
        wr_data_o <= '0;
        wr_mask_o <= '0;
      end
    end
  end
endmodule

// File: rtl/wr_data_aligner_chk.sv
`timescale 1ns/1ps
module wr_data_aligner_chk #(
  parameter int NLANE = 4,
  parameter int DW    = 64,
  parameter int MW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             phy_init_done,
  input logic             in_wr,
  input logic             wr_cmd_o,
  input logic [NLANE-1:0] wr_en_unshifted_o,
  input logic [NLANE-1:0] wr_en_o,
  input logic [DW-1:0]    wr_data_o,
  input logic [MW-1:0]    wr_mask_o,
  input logic             wr_err_o
);
  AST_UNSHIFT_IS_CMD: assert property (@(posedge clk) disable iff (rst)
    wr_en_unshifted_o == {NLANE{wr_cmd_o}}); // R1

  AST_LANES_SAME: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o == '0) || (wr_en_o == '1)); // R7

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en_o[0]) |-> (wr_data_o == '0 && wr_mask_o == '0)); // R11

  AST_CMD_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_o |-> $past(phy_init_done)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |=> wr_err_o); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_err_o) |-> $past(in_wr && !phy_init_done)); // R9
endmodule

bind wr_data_aligner wr_data_aligner_chk #(.NLANE(NLANE), .DW(DFI_DW), .MW(DFI_MW)) chk_i (
  .clk(clk), .rst(rst), .phy_init_done(phy_init_done), .in_wr(in_wr),
  .wr_cmd_o(wr_cmd_o), .wr_en_unshifted_o(wr_en_unshifted_o), .wr_en_o(wr_en_o),
  .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o), .wr_err_o(wr_err_o)
);

// File: tb/wr_data_aligner_tb_top.sv
`timescale 1ns/1ps
module wr_data_aligner_tb_top;
  localparam int DW = 64;
  localparam int MW = 8;
  localparam int NL = 4;
  localparam int HN = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          phy_init_done = 1'b0;
  logic          cfg_ddr2 = 1'b0;
  logic [2:0]    cfg_cwl = '0;
  logic [2:0]    cfg_phy_wlat = '0;
  logic          in_wr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [MW-1:0] in_mask = '0;
  logic          wr_cmd_o;
  logic [NL-1:0] wr_en_unshifted_o;
  logic [NL-1:0] wr_en_o;
  logic [DW-1:0] wr_data_o;
  logic [MW-1:0] wr_mask_o;
  logic          wr_err_o;

  wr_data_aligner dut_i (
    .clk(clk), .rst(rst), .phy_init_done(phy_init_done), .cfg_ddr2(cfg_ddr2),
    .cfg_cwl(cfg_cwl), .cfg_phy_wlat(cfg_phy_wlat), .in_wr(in_wr),
    .in_data(in_data), .in_mask(in_mask), .wr_cmd_o(wr_cmd_o),
    .wr_en_unshifted_o(wr_en_unshifted_o), .wr_en_o(wr_en_o),
    .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o), .wr_err_o(wr_err_o)
  );

  always #5 clk = ~clk;

  int       n_vec = 0;
  int       n_bad = 0;
  int       n = HN;
  int       bench_d = 1;
  logic     exp_err = 1'b0;
  string    tag_en = "R2";
  string    tag_d = "R3";
  logic          acc_h [HN];
  logic [DW-1:0] d_h   [HN];
  logic [MW-1:0] m_h   [HN];

  function automatic int ref_delay(logic ddr2, logic [2:0] cwl, logic [2:0] wl);
    return ddr2 ? 1 + int'(cwl) + int'(wl) : 1;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h", tag, what, n, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < HN; i++) begin
      acc_h[i] = 1'b0; d_h[i] = '0; m_h[i] = '0;
    end
  endtask

  task automatic check_outputs();
    logic e_cmd, e_en, e_dv;
    int i_d;
    e_cmd = acc_h[n % HN];
    e_en  = acc_h[(n - bench_d + 1 + HN) % HN];
    i_d   = (n - bench_d + HN) % HN;
    e_dv  = acc_h[i_d];
    chk(wr_cmd_o === e_cmd, "R1", "command", 64'(wr_cmd_o), 64'(e_cmd));
    chk(wr_en_unshifted_o === {NL{e_cmd}}, "R1", "unshifted enable",
        64'(wr_en_unshifted_o), 64'({NL{e_cmd}}));
    chk(wr_en_o === '0 || wr_en_o === '1, "R7", "lane agreement", 64'(wr_en_o), 64'(0));
    chk(wr_en_o[0] === e_en, tag_en, "shifted enable", 64'(wr_en_o[0]), 64'(e_en));
    chk(wr_data_o === (e_dv ? d_h[i_d] : '0), e_dv ? tag_d : "R11", "data",
        wr_data_o, e_dv ? d_h[i_d] : '0);
    chk(wr_mask_o === (e_dv ? m_h[i_d] : '0), e_dv ? tag_d : "R11", "mask",
        64'(wr_mask_o), 64'(e_dv ? m_h[i_d] : '0));
    chk(wr_err_o === exp_err, "R9", "error flag", 64'(wr_err_o), 64'(exp_err));
  endtask

  task automatic tick(input logic w);
    in_wr   = w;
    in_data = {$urandom, $urandom};
    in_mask = MW'($urandom);
    n++;
    acc_h[n % HN] = w & phy_init_done;
    d_h[n % HN]   = in_data;
    m_h[n % HN]   = in_mask;
    if (w && !phy_init_done) exp_err = 1'b1;
    if (!phy_init_done) bench_d = ref_delay(cfg_ddr2, cfg_cwl, cfg_phy_wlat);
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) tick(1'b0);
  endtask

  task automatic run_random(input int bursts);
    for (int b = 0; b < bursts; b++) begin
      int len, gap;
      len = ($urandom % 2 == 0) ? 2 : 4;
      gap = int'($urandom % 4);
      for (int i = 0; i < len; i++) tick(1'b1);
      for (int i = 0; i < gap; i++) tick(1'b0);
    end
    drain();
  endtask

  task automatic back_to_back(input int bursts);
    tag_en = "R6";
    for (int b = 0; b < bursts; b++)
      for (int i = 0; i < 4; i++) tick(1'b1);
    drain();
    tag_en = "R2";
  endtask

  task automatic set_cfg(input logic ddr2, input logic [2:0] cwl,
                         input logic [2:0] wl, input string tag);
    phy_init_done = 1'b0;
    cfg_ddr2 = ddr2; cfg_cwl = cwl; cfg_phy_wlat = wl;
    for (int i = 0; i < 3; i++) tick(1'b0);
    phy_init_done = 1'b1;
    tag_d = tag;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_wr = 1'b0;
    phy_init_done = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    // R10: everything cleared during reset
    chk(wr_cmd_o === 1'b0, "R10", "reset command", 64'(wr_cmd_o), 0);
    chk(wr_en_o === '0 && wr_en_unshifted_o === '0, "R10", "reset enables",
        64'({wr_en_o, wr_en_unshifted_o}), 0);
    chk(wr_data_o === '0 && wr_mask_o === '0, "R10", "reset data", wr_data_o, 0);
    chk(wr_err_o === 1'b0, "R10", "reset error flag", 64'(wr_err_o), 0);
    clear_hist();
    exp_err = 1'b0;
    bench_d = 1;
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired at edge %0d", n);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_hist();
    @(negedge clk);
    do_reset();
    // R10: reset delay is the DDR1 value
    set_cfg(1'b0, 3'd5, 3'd5, "R3");
    cfg_ddr2 = 1'b0;
    run_random(60);
    back_to_back(6);

    set_cfg(1'b1, 3'd3, 3'd0, "R4");
    run_random(50);
    back_to_back(4);

    set_cfg(1'b1, 3'd3, 3'd1, "R5");
    run_random(40);

    set_cfg(1'b1, 3'd7, 3'd7, "R4");
    run_random(40);
    back_to_back(5);

    // R8: configuration pins move while initialized; delay must stay at 15
    cfg_ddr2 = 1'b0; cfg_cwl = 3'd0; cfg_phy_wlat = 3'd0;
    tag_d = "R8";
    run_random(30);

    // R9: writes offered before initialization are dropped and flagged
    phy_init_done = 1'b0;
    cfg_ddr2 = 1'b0;
    tick(1'b0);
    tick(1'b1);
    tick(1'b1);
    tick(1'b0);
    phy_init_done = 1'b1;
    tag_d = "R3";
    run_random(10);

    // R9/R10: reset clears the sticky flag, then normal traffic resumes
    do_reset();
    set_cfg(1'b0, 3'd0, 3'd0, "R3");
    run_random(20);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule